// File: doc/BRIEF.md
# Serial bus hold controller

This block pauses a serial memory interface without deselecting it. It watches an active-low chip select, an active-low hold input and the serial clock, and keeps an internal hold state. While that state is set, the receive shift register and its bit counter are frozen, and an override output tells the pad logic to put the serial output into high impedance. Entry into and exit from the hold state happen only while the serial clock is low, so a pause never cuts a clock pulse in half. Any program or erase cycle that is already running elsewhere in the device is not affected.

All inputs are sampled by a fast system clock, which is assumed to be already synchronous. A rising serial clock edge is detected by comparing the sampled serial clock with its value one system clock earlier. If the device is deselected while held, the interface is reset and a one-cycle pulse is raised. From then on a low hold input is ignored until that input has been seen high again. This stops the interface from going straight back into hold when it is selected again.

Top module: `serial_hold_ctrl`

## Requirements
- R1: After reset, with the chip deselected: freeze is 0, outOverride is 1, ifaceReset is 0, shiftWord is 0 and bitCount is 0.
- R2: While selected and not held, each rising serial clock edge shifts sdi into bit 0 of shiftWord, most significant bit first, and increments bitCount. After WORD_W bits, bitCount wraps to 0 and byteStrobe pulses for one cycle. All of this is visible in the cycle after the edge is sampled.
- R3: With chip select low, the hold input low and the serial clock sampled low, freeze is 1 in the next cycle.
- R4: While the serial clock is sampled high, freeze keeps its value. A hold request made while the clock is high takes effect only once the clock is sampled low.
- R5: With the hold input sampled high and the serial clock sampled low, freeze is 0 in the next cycle. A release made while the clock is high waits for the clock to go low.
- R6: While frozen, serial clock edges and sdi have no effect: shiftWord and bitCount keep their values. After release, shifting resumes at the first rising edge and the count continues from where it stopped.
- R7: outOverride is 1 whenever freeze is 1 or chip select is high, and 0 otherwise.
- R8: Chip select high clears freeze, shiftWord and bitCount in the next cycle. While deselected, a low hold input never sets freeze.
- R9: Deselecting while frozen raises ifaceReset for exactly one cycle and arms a lockout. While the lockout is armed, a low hold input does not set freeze and shifting goes on. The lockout clears once the hold input is sampled high.
- R10: If the hold input is high in the same cycle that deselection ends a hold, no lockout is armed. A low hold input after reselection then sets freeze again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock (sampled) |
| holdN | input | 1 | Active-low hold request |
| sdi | input | 1 | Serial data input |
| freeze | output | 1 | Hold state; freezes the shift logic |
| outOverride | output | 1 | 1 forces the serial output to high impedance |
| ifaceReset | output | 1 | One-cycle pulse when deselection ends a hold |
| shiftWord | output | WORD_W | Receive shift register |
| bitCount | output | $clog2(WORD_W) | Bits received in the current word |
| byteStrobe | output | 1 | One-cycle pulse when a word completes |

## Verification
Ending a hold by deselection and releasing the hold input can happen in the same system clock cycle. The bench provokes this by raising chip select and the hold input in one step while frozen. It then judges the result by reselecting with the hold input low: freeze must rise in the next cycle, because no lockout was armed. In the companion case the hold input stays low across deselection, and the same reselection must leave freeze at 0.

// File: rtl/serial_hold_pkg.sv
package serial_hold_pkg;
  // Strobes passed from the hold control to the shift datapath
  typedef struct packed {
    logic shiftEn;  // sample sdi on this cycle
    logic clear;    // deselected: clear word and count
  } holdStrobe_t;
endpackage

// File: rtl/serial_hold_fsm.sv
module serial_hold_fsm
  import serial_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sck,
  input  logic        holdN,
  output holdStrobe_t strobe,
  output logic        holdState,
  output logic        lockout,
  output logic        ifaceReset
);
  logic sckPrev;
  logic holdReq;
  logic sckRise;

  // A low hold input counts as a request only when no lockout is armed
  assign holdReq = ~holdN & ~lockout;
  assign sckRise = sck & ~sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev    <= 1'b0;
      holdState  <= 1'b0;
      lockout    <= 1'b0;
      ifaceReset <= 1'b0;
    end else begin
      sckPrev    <= sck;
      ifaceReset <= csN & holdState;
      // The hold state may change only while the serial clock is low
      if (csN) begin
        holdState <= 1'b0;
      end else if (!sck) begin
        holdState <= holdReq;
      end
      // A released hold input wins over arming the lockout
      if (holdN) begin
        lockout <= 1'b0;
      end else if (csN && holdState) begin
        lockout <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.shiftEn = ~csN & ~holdState & sckRise;
    strobe.clear   = csN;
  end
endmodule

// File: rtl/serial_hold_shift.sv
module serial_hold_shift
  import serial_hold_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  holdStrobe_t       strobe,
  input  logic              sdi,
  output logic [WORD_W-1:0] shiftWord,
  output logic [CNT_W-1:0]  bitCount,
  output logic              byteStrobe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord  <= '0;
      bitCount   <= '0;
      byteStrobe <= 1'b0;
    end else if (strobe.clear) begin
      shiftWord  <= '0;
      bitCount   <= '0;
      byteStrobe <= 1'b0;
    end else if (strobe.shiftEn) begin
      shiftWord  <= {shiftWord[WORD_W-2:0], sdi};
      byteStrobe <= (bitCount == LAST_BIT);
      bitCount   <= (bitCount == LAST_BIT) ? '0 : bitCount + 1'b1;
    end else begin
      byteStrobe <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_hold_ctrl.sv
module serial_hold_ctrl
  import serial_hold_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              holdN,
  input  logic              sdi,
  output logic              freeze,
  output logic              outOverride,
  output logic              ifaceReset,
  output logic [WORD_W-1:0] shiftWord,
  output logic [CNT_W-1:0]  bitCount,
  output logic              byteStrobe
);
  holdStrobe_t strobe;
  logic        holdState;
  logic        lockoutFlag;

  serial_hold_fsm u_fsm (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .holdN(holdN),
    .strobe(strobe), .holdState(holdState), .lockout(lockoutFlag),
    .ifaceReset(ifaceReset)
  );

  serial_hold_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdi(sdi),
    .shiftWord(shiftWord), .bitCount(bitCount), .byteStrobe(byteStrobe)
  );

  assign freeze      = holdState;
  assign outOverride = holdState | csN;
endmodule

// File: rtl/serial_hold_ctrl_chk.sv
module serial_hold_ctrl_chk #(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              sck,
  input logic              holdN,
  input logic              freeze,
  input logic              ifaceReset,
  input logic [WORD_W-1:0] shiftWord,
  input logic [CNT_W-1:0]  bitCount,
  input logic              byteStrobe,
  input logic              lockout
);
  a_r2_strobe_wraps: assert property (@(posedge clk) disable iff (!rstN)
    byteStrobe |-> bitCount == '0);
  a_r3_enter_low: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !sck && !holdN && !lockout) |=> freeze);
  a_r4_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sck) |=> $stable(freeze));
  a_r5_exit_low: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !sck && holdN) |=> !freeze);
  a_r6_frozen_stable: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !csN) |=> ($stable(shiftWord) && $stable(bitCount)));
  a_r8_deselect_clears: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!freeze && bitCount == '0));
  a_r9_lockout_arms: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && csN && !holdN) |=> lockout);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ifaceReset |=> !ifaceReset);
  a_r10_release_wins: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && csN && holdN) |=> !lockout);
endmodule

bind serial_hold_ctrl serial_hold_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .holdN(holdN),
  .freeze(freeze), .ifaceReset(ifaceReset), .shiftWord(shiftWord),
  .bitCount(bitCount), .byteStrobe(byteStrobe), .lockout(lockoutFlag)
);

// File: tb/serial_hold_ctrl_bench.sv
module serial_hold_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 8;
  localparam int CNT_W = $clog2(WORD_W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, holdN = 1'b1, sdi = 1'b0;
  logic freeze, outOverride, ifaceReset, byteStrobe;
  logic [WORD_W-1:0] shiftWord;
  logic [CNT_W-1:0]  bitCount;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_hold_ctrl #(.WORD_W(WORD_W)) u_serial_hold_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .holdN(holdN), .sdi(sdi),
    .freeze(freeze), .outOverride(outOverride), .ifaceReset(ifaceReset),
    .shiftWord(shiftWord), .bitCount(bitCount), .byteStrobe(byteStrobe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply inputs at a falling edge, return after the next rising edge has taken them
  task automatic step(input logic c, input logic k, input logic h, input logic d);
    csN = c; sck = k; holdN = h; sdi = d;
    @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    step(1'b0, 1'b0, 1'b1, b);
    step(1'b0, 1'b1, 1'b1, b);
  endtask

  task automatic testReset;
    chk("R1 freeze", 32'(freeze), 0);
    chk("R1 outOverride", 32'(outOverride), 1);
    chk("R1 ifaceReset", 32'(ifaceReset), 0);
    chk("R1 shiftWord", 32'(shiftWord), 0);
    chk("R1 bitCount", 32'(bitCount), 0);
  endtask

  task automatic testShiftByte;
    logic [7:0] pat = 8'hA5;
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 selected override low", 32'(outOverride), 0);
    for (int i = 7; i >= 4; i--) sendBit(pat[i]);
    chk("R2 half count", 32'(bitCount), 4);
    chk("R2 half word", 32'(shiftWord), 32'h0A);
    for (int i = 3; i >= 0; i--) sendBit(pat[i]);
    chk("R2 full word", 32'(shiftWord), 32'hA5);
    chk("R2 count wraps", 32'(bitCount), 0);
    chk("R2 strobe", 32'(byteStrobe), 1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 strobe one cycle", 32'(byteStrobe), 0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R8 word cleared", 32'(shiftWord), 0);
    chk("R7 deselected override", 32'(outOverride), 1);
  endtask

  task automatic testHoldClockLow;
    step(1'b0, 1'b0, 1'b1, 1'b0);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 freeze at once", 32'(freeze), 1);
    chk("R7 override in hold", 32'(outOverride), 1);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b1);
    end
    chk("R6 word frozen", 32'(shiftWord), 32'h05);
    chk("R6 count frozen", 32'(bitCount), 3);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5 release at once", 32'(freeze), 0);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    chk("R6 resumed word", 32'(shiftWord), 32'hB3);
    chk("R6 resumed strobe", 32'(byteStrobe), 1);
    step(1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testHoldClockHigh;
    step(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R2 one bit", 32'(bitCount), 1);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R4 no freeze while high", 32'(freeze), 0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 freeze after low", 32'(freeze), 1);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R5 release waits", 32'(freeze), 1);
    chk("R6 rise in hold ignored", 32'(bitCount), 1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5 release after low", 32'(freeze), 0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6 first rise shifts", 32'(bitCount), 2);
    chk("R6 word after resume", 32'(shiftWord), 32'h02);
    step(1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testDeselectedHold;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 hold ignored deselected", 32'(freeze), 0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testLockout;
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 frozen before deselect", 32'(freeze), 1);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 reset pulse", 32'(ifaceReset), 1);
    chk("R8 freeze cleared", 32'(freeze), 0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 pulse one cycle", 32'(ifaceReset), 0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 no re-entry", 32'(freeze), 0);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R9 shifting during lockout", 32'(bitCount), 1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 hold after lockout cleared", 32'(freeze), 1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testSameCycle;
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 frozen", 32'(freeze), 1);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R10 reset pulse", 32'(ifaceReset), 1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 no lockout re-entry", 32'(freeze), 1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testShiftByte();
    testHoldClockLow();
    testHoldClockHigh();
    testDeselectedHold();
    testLockout();
    testSameCycle();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule